// File: doc/BRIEF.md
# Multiplexed Converter Frame Sequencer

This block sets the timing of one multiplexed converter frame. It advances once per pulse of a slow clock enable, which runs at 32768 Hz in the usual system. The core clock may be much faster. Each frame opens with one settling cycle, and no sampling takes place during that cycle. A run of conversion slots follows, one slot per multiplexer channel, in ascending channel order. Software chooses the number of slots per frame and sets how many slow cycles each slot lasts through a two-bit filter-length code.

The sequencer takes a new configuration only at a frame boundary. It also compares the slot time against the fourteen usable cycles of a fifteen-cycle frame. When the two do not match, it raises an error flag and does not stop. The frame then grows or shrinks to fit the configured slots. Dropping the enable returns the sequencer to a quiet idle state. The next frame starts on the first enable pulse after the enable is raised again.

Top module: `fseq_frame`

## Requirements
- R1: A frame lasts N×L+1 enable pulses, where N is the sampled conversion count and L is the cycles per conversion. The default setting of N=7 with code 01 gives 15.
- R2: `frame_sof` is high for exactly one core clock. That clock follows the enable pulse that starts a frame, and `settle` is high during it.
- R3: `settle` is high during the first cycle of every frame and only during that cycle. `conv_busy` is low during that cycle.
- R4: `conv_busy` is high during the N×L cycles that follow the settling cycle. The first of those cycles has channel 0.
- R5: `chan` holds the index of the current conversion (0 to N-1) for L cycles per conversion. It reads 0 whenever `conv_busy` is low.
- R6: The filter-length code maps to cycles per conversion as follows: 00→1, 01→2, 10→3, 11→4.
- R7: `cfg_err` is high for the whole of any frame whose N×L is not 14. It is low for frames whose N×L is 14 and low while idle.
- R8: `conv_count` and `flen_code` are sampled only on the pulse that starts a frame. A change in the middle of a frame does not alter that frame.
- R9: With `en` low, every output is 0 one core clock later. After `en` rises, the first frame starts on the next enable pulse.
- R10: Outputs do not change on a core clock without an enable pulse, as long as `en` stays high.
- R11: With N=0, every frame consists of the settling cycle alone, and `cfg_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | slow-clock enable pulse, one core clock wide |
| en | input | 1 | sequencer enable |
| conv_count | input | 4 | conversions per frame |
| flen_code | input | 2 | filter-length code |
| chan | output | 4 | current conversion channel index |
| settle | output | 1 | settling cycle in progress |
| conv_busy | output | 1 | conversion cycle in progress |
| frame_sof | output | 1 | start-of-frame pulse |
| cfg_err | output | 1 | current frame does not fill 14 cycles |

## Verification
The assertions assume that `tick` is never high on two core clocks in a row unless the stimulus means a slow cycle on every clock. They also assume that the inputs change only between core clock edges. The bench drives every input on the falling edge. It produces `tick` from a divider whose ratio it sets itself, including a ratio of one. It changes the configuration both at frame boundaries and in the middle of frames, and it drops the enable partway through a frame.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_e;

  // slow cycles spent on each conversion for a filter-length code
  function automatic int cyc_per_conv(input int code);
    return code + 1;
  endfunction

  // slow cycles taken by all conversions of one frame
  function automatic int frame_fill(input int n_conv, input int len);
    return n_conv * len;
  endfunction

endpackage

// File: rtl/fseq_cfg_hold.sv
module fseq_cfg_hold #(
  parameter int CPF_W   = 4,
  parameter int FLC_W   = 2,
  parameter int LEN_W   = 3,
  parameter int FILL    = 14,
  parameter int CPF_DEF = 7,
  parameter int FLC_DEF = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CPF_W-1:0] cpf_in,
  input  logic [FLC_W-1:0] flc_in,
  output logic [CPF_W-1:0] n_q,
  output logic [LEN_W-1:0] len_q,
  output logic             mismatch
);
  import fseq_pkg::*;

  int len_in;
  assign len_in = cyc_per_conv(int'(flc_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q      <= CPF_W'(CPF_DEF);
      len_q    <= LEN_W'(cyc_per_conv(FLC_DEF));
      mismatch <= 1'b0;
    end else if (load) begin
      n_q      <= cpf_in;
      len_q    <= LEN_W'(len_in);
      mismatch <= frame_fill(int'(cpf_in), len_in) != FILL;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(n_q) && $stable(len_q) && $stable(mismatch))); // R8

endmodule

// File: rtl/fseq_slot_ctr.sv
module fseq_slot_ctr #(
  parameter int CPF_W = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CPF_W-1:0] n_lim,
  input  logic [LEN_W-1:0] len_lim,
  output logic [CPF_W-1:0] chan,
  output logic             last_sub,
  output logic             last_chan
);
  logic [LEN_W-1:0] sub;

  assign last_sub  = (sub == len_lim - LEN_W'(1));
  assign last_chan = (chan == n_lim - CPF_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sub  <= '0;
      chan <= '0;
    end else if (step) begin
      if (last_sub) begin
        sub  <= '0;
        chan <= chan + CPF_W'(1);
      end else begin
        sub <= sub + LEN_W'(1);
      end
    end
  end

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (chan < n_lim)); // R5
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (sub < len_lim)); // R6

endmodule

// File: rtl/fseq_frame.sv
module fseq_frame #(
  parameter int CPF_W = 4,
  parameter int FLC_W = 2,
  parameter int FILL  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [CPF_W-1:0] conv_count,
  input  logic [FLC_W-1:0] flen_code,
  output logic [CPF_W-1:0] chan,
  output logic             settle,
  output logic             conv_busy,
  output logic             frame_sof,
  output logic             cfg_err
);
  import fseq_pkg::*;

  localparam int LEN_W = $clog2((1 << FLC_W) + 1);

  phase_e           phase;
  logic [CPF_W-1:0] n_q;
  logic [LEN_W-1:0] len_q;
  logic             mismatch;
  logic [CPF_W-1:0] slot_chan;
  logic             last_sub, last_chan;

  // named internal events
  logic conv_done, empty_frame, frame_begin, slot_step, slot_clear;

  assign conv_done   = (phase == PH_CONV) && last_sub && last_chan;
  assign empty_frame = (phase == PH_SETTLE) && (n_q == '0);
  assign frame_begin = en && tick && ((phase == PH_IDLE) || empty_frame || conv_done);
  assign slot_step   = en && tick && (phase == PH_CONV) && !conv_done;
  assign slot_clear  = !en || (phase != PH_CONV) || frame_begin;

  fseq_cfg_hold #(
    .CPF_W(CPF_W), .FLC_W(FLC_W), .LEN_W(LEN_W), .FILL(FILL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(frame_begin),
    .cpf_in(conv_count), .flc_in(flen_code),
    .n_q(n_q), .len_q(len_q), .mismatch(mismatch)
  );

  fseq_slot_ctr #(.CPF_W(CPF_W), .LEN_W(LEN_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .clear(slot_clear), .step(slot_step),
    .n_lim(n_q), .len_lim(len_q),
    .chan(slot_chan), .last_sub(last_sub), .last_chan(last_chan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase     <= PH_IDLE;
      frame_sof <= 1'b0;
    end else begin
      frame_sof <= frame_begin;
      if (frame_begin)
        phase <= PH_SETTLE;
      else if (tick && phase == PH_SETTLE)
        phase <= PH_CONV;
    end
  end

  assign chan      = slot_chan;
  assign settle    = (phase == PH_SETTLE);
  assign conv_busy = (phase == PH_CONV);
  assign cfg_err   = mismatch && (phase != PH_IDLE);

  AST_SOF_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> settle); // R2
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == PH_IDLE && chan == '0 && !frame_sof)); // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ($stable(phase) && $stable(chan))); // R10
  AST_CONV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && settle && n_q != '0) |=> (conv_busy && chan == '0)); // R4
  AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && empty_frame) |=> (settle && frame_sof)); // R11
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !cfg_err); // R7

endmodule

// File: tb/fseq_frame_bench.sv
module fseq_frame_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic [3:0] conv_count = 4'd7;
  logic [1:0] flen_code = 2'd1;
  logic [3:0] chan;
  logic       settle, conv_busy, frame_sof, cfg_err;

  int checks = 0;
  int fails = 0;
  int tick_div = 3;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fseq_frame u_fseq_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
    .conv_count(conv_count), .flen_code(flen_code),
    .chan(chan), .settle(settle), .conv_busy(conv_busy),
    .frame_sof(frame_sof), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: position within frame, -1 when idle
  int m_pos = -1, m_n = 7, m_l = 2;
  bit m_sof = 0, m_tick_seen = 0, m_en_seen = 0;
  always @(posedge clk) begin
    m_tick_seen = tick;
    m_en_seen   = en;
    if (!rst_n || !en) begin
      m_pos = -1;
      m_sof = 0;
    end else begin
      m_sof = 0;
      if (tick) begin
        if (m_pos < 0 || m_pos == m_n * m_l) begin
          m_n   = conv_count;
          m_l   = flen_code + 1;     // R6 code to length
          m_pos = 0;
          m_sof = 1;
        end else begin
          m_pos++;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  bit        have_prev = 0;
  logic [3:0] p_chan;
  logic       p_settle, p_busy, p_err;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_chan;
      e_chan = (m_pos > 0) ? (m_pos - 1) / m_l : 0;
      chk(settle === (m_pos == 0), "R3 settle", settle, m_pos == 0);
      chk(conv_busy === (m_pos > 0), "R4 conv_busy", conv_busy, m_pos > 0);
      chk(int'(chan) == e_chan, "R5 chan", chan, e_chan);
      chk(frame_sof === m_sof, "R2 frame_sof", frame_sof, m_sof);
      chk(cfg_err === (m_pos >= 0 && m_n * m_l != 14), "R7 cfg_err", cfg_err,
          m_pos >= 0 && m_n * m_l != 14);
      if (have_prev && m_en_seen && !m_tick_seen) begin
        chk(chan === p_chan && settle === p_settle && conv_busy === p_busy &&
            cfg_err === p_err, "R10 hold without tick", {settle, conv_busy},
            {p_settle, p_busy});
      end
      p_chan = chan; p_settle = settle; p_busy = conv_busy; p_err = cfg_err;
      have_prev = 1;
    end else begin
      have_prev = 0;
    end
  end

  task automatic wait_sof();
    do @(negedge clk); while (!frame_sof);
  endtask

  task automatic frame_len(input int exp, input string tag);
    int n;
    wait_sof();
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_sof);
    chk(n == exp * tick_div, tag, n / tick_div, exp);
  endtask

  task automatic set_cfg(input int n, input int c);
    @(negedge clk);
    conv_count = 4'(n);
    flen_code  = 2'(c);
    wait_sof();          // takes effect at this boundary
  endtask

  initial begin
    fork
      begin : tick_gen
        int cnt = 0;
        forever begin
          @(negedge clk);
          tick = (cnt == 0);
          cnt = (cnt + 1 >= tick_div) ? 0 : cnt + 1;
        end
      end
      begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({chan, settle, conv_busy, frame_sof, cfg_err} == 8'd0, "R9 reset quiet",
            {chan, settle, conv_busy, frame_sof, cfg_err}, 0);
        en = 1'b1;
        frame_len(15, "R1 default frame length");
        @(negedge clk);
        chk(cfg_err == 1'b0, "R7 default no error", cfg_err, 0);
        set_cfg(14, 0);
        frame_len(15, "R6 code 00 length");
        set_cfg(4, 2);
        frame_len(13, "R6 code 10 length");
        @(negedge clk);
        chk(cfg_err == 1'b1, "R7 short frame error", cfg_err, 1);
        set_cfg(5, 3);
        frame_len(21, "R6 code 11 length");
        set_cfg(0, 1);
        frame_len(1, "R11 empty frame");
        chk(cfg_err == 1'b1, "R11 empty error", cfg_err, 1);
        set_cfg(7, 1);
        // R8: change in mid-frame, frame keeps its length
        begin
          int n;
          wait_sof();
          n = 0;
          repeat (5) begin @(negedge clk); n++; end
          conv_count = 4'd2; flen_code = 2'd0;
          do begin @(negedge clk); n++; end while (!frame_sof);
          chk(n == 15 * tick_div, "R8 mid-frame change ignored", n / tick_div, 15);
        end
        frame_len(3, "R8 new config at boundary");
        // R9: disable mid-frame
        conv_count = 4'd7; flen_code = 2'd1;
        wait_sof();
        repeat (7) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk({chan, settle, conv_busy, frame_sof, cfg_err} == 8'd0, "R9 disabled quiet",
            {chan, settle, conv_busy, frame_sof, cfg_err}, 0);
        repeat (10) @(negedge clk);
        en = 1'b1;
        frame_len(15, "R9 restart frame length");
        // tick on every clock
        tick_div = 1;
        wait_sof();
        frame_len(15, "R1 continuous tick length");
        set_cfg(15, 3);
        frame_len(61, "R7 long frame length");
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule